// File: doc/BRIEF.md
# Firmware Cycle DMA Address Translator

This block decides, for each firmware-space read or write cycle arriving from the host, whether the cycle can be served straight from a window of CPU memory or must be handed to the CPU for interactive handling. The inbound address is first ANDed with a programmable mask, so one memory region can repeat across the whole firmware space. The masked address is then shifted by a programmable start offset, checked against an inclusive end offset, and relocated into CPU memory by adding a 64-bit base.

Qualification also depends on per-direction enables and an optional 4-bit ID select filter. For every presented cycle the block reports, one clock later, either a DMA hit with the 64-bit word address and byte lane, or a fallback to the interactive path. Seven 32-bit configuration registers are written and read back through a small select/data port.

Top module: `fwdma_xlate_top`

## Requirements
- R1: After reset every configuration register reads 0x00000000 and `out_valid`, `dma_hit` and `fallback` are low.
- R2: A write with `cfg_we` high stores `cfg_wdata` in the register chosen by `cfg_sel` (0 control, 1 mask, 2 start offset, 3 end offset, 4 base low, 5 base high, 6 window length); `cfg_rdata` returns the selected register, with bits 3:0 of base low and of window length always reading zero.
- R3: The cycle address is ANDed with the mask register before the window check and before relocation.
- R4: A cycle is inside the window when (masked address + start offset), computed without wrap, is no greater than the end offset; the end offset itself is inside.
- R5: On a hit the CPU address is base + start offset + masked address; `cpu_word_addr` carries it with bits 2:0 cleared and `byte_lane` carries those three bits.
- R6: Control bit 0 enables DMA for reads and control bit 1 enables it for writes, each independently; a cycle whose direction is not enabled falls back.
- R7: When control bit 2 is set, a cycle hits only if `cyc_idsel` equals control bits 7:4; when clear, the ID select is ignored.
- R8: For each presented cycle exactly one of `dma_hit` and `fallback` is raised; with no cycle presented both stay low.
- R9: Results appear on the outputs on the clock edge after the edge that sampled `cyc_valid`, and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected configuration register (combinational) |
| cyc_valid | input | 1 | A firmware cycle is presented this clock |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_addr | input | 32 | Firmware-space byte address |
| cyc_idsel | input | 4 | ID select of the cycle |
| out_valid | output | 1 | Result of the cycle presented one clock earlier |
| dma_hit | output | 1 | Cycle is served from the CPU memory window |
| fallback | output | 1 | Cycle goes to CPU-interactive handling |
| cpu_word_addr | output | 64 | Translated CPU address, bits 2:0 cleared |
| byte_lane | output | 3 | Byte within the 64-bit word |

## Verification
Register readback is combinational, so the bench sets the select and checks `cfg_rdata` a moment later in the same low clock phase, while a written value is read only after the write edge. Translation results are registered once: the bench drives a cycle on a falling edge, lets one rising edge capture it, and checks all outputs at the next falling edge, which is where R9 places them. It also checks the falling edge after that to see the result has gone.

// File: rtl/fwdma_pkg.sv
package fwdma_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL    = 3'd0,
    SEL_MASK    = 3'd1,
    SEL_START   = 3'd2,
    SEL_END     = 3'd3,
    SEL_BASE_LO = 3'd4,
    SEL_BASE_HI = 3'd5,
    SEL_LENGTH  = 3'd6
  } cfg_sel_e;

  localparam int NUM_REGS = 7;

  // control register bit positions
  localparam int CTRL_RD_EN  = 0;
  localparam int CTRL_WR_EN  = 1;
  localparam int CTRL_FLT_EN = 2;
  localparam int CTRL_FLT_LO = 4;
endpackage

// File: rtl/fwdma_cfg_regs.sv
module fwdma_cfg_regs
  import fwdma_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int ALIGN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] ctrl,
  output logic [REG_W-1:0] mask,
  output logic [REG_W-1:0] start_off,
  output logic [REG_W-1:0] end_off,
  output logic [REG_W-1:0] base_lo,
  output logic [REG_W-1:0] base_hi
);
  logic [REG_W-1:0] regs_q [NUM_REGS];
  logic [REG_W-1:0] regs_d [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    // registers with hardwired-zero low bits
    localparam bit ALIGNED = (g == int'(SEL_BASE_LO)) || (g == int'(SEL_LENGTH));
    localparam logic [REG_W-1:0] KEEP = ALIGNED ? ({REG_W{1'b1}} << ALIGN_W)
                                                : {REG_W{1'b1}};

    always_comb begin
      regs_d[g] = regs_q[g];
      if (we && (sel == SEL_W'(g))) regs_d[g] = wdata & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= regs_d[g];
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(sel) < NUM_REGS) rdata = regs_q[sel];
  end

  assign ctrl      = regs_q[SEL_CTRL];
  assign mask      = regs_q[SEL_MASK];
  assign start_off = regs_q[SEL_START];
  assign end_off   = regs_q[SEL_END];
  assign base_lo   = regs_q[SEL_BASE_LO];
  assign base_hi   = regs_q[SEL_BASE_HI];
endmodule

// File: rtl/fwdma_map.sv
module fwdma_map #(
  parameter int REG_W   = 32,
  parameter int IDSEL_W = 4,
  localparam int CPU_AW = 2 * REG_W
) (
  input  logic               valid,
  input  logic               is_write,
  input  logic [REG_W-1:0]   addr,
  input  logic [IDSEL_W-1:0] idsel,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic               flt_en,
  input  logic [IDSEL_W-1:0] flt_val,
  input  logic [REG_W-1:0]   mask,
  input  logic [REG_W-1:0]   start_off,
  input  logic [REG_W-1:0]   end_off,
  input  logic [CPU_AW-1:0]  base,
  output logic               hit,
  output logic [CPU_AW-1:0]  cpu_addr
);
  logic [REG_W-1:0] masked;
  logic [REG_W:0]   win_off;
  logic             in_window, dir_ok, id_ok;

  always_comb begin
    masked    = addr & mask;
    win_off   = {1'b0, masked} + {1'b0, start_off};
    in_window = (win_off <= {1'b0, end_off});
    dir_ok    = is_write ? wr_en : rd_en;
    id_ok     = !flt_en || (idsel == flt_val);
    hit       = valid && in_window && dir_ok && id_ok;
    cpu_addr  = base + {{(CPU_AW-REG_W-1){1'b0}}, win_off};
  end
endmodule

// File: rtl/fwdma_result_reg.sv
module fwdma_result_reg #(
  parameter int CPU_AW = 64,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              hit,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic              out_valid,
  output logic              dma_hit,
  output logic              fallback,
  output logic [CPU_AW-1:0] cpu_word_addr,
  output logic [LANE_W-1:0] byte_lane
);
  logic              vld_d, hit_d, fb_d;
  logic              addr_en;
  logic [CPU_AW-1:0] word_d;
  logic [LANE_W-1:0] lane_d;

  always_comb begin
    vld_d   = valid;
    hit_d   = valid && hit;
    fb_d    = valid && !hit;
    addr_en = valid;
    word_d  = {cpu_addr[CPU_AW-1:LANE_W], {LANE_W{1'b0}}};
    lane_d  = cpu_addr[LANE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dma_hit   <= 1'b0;
      fallback  <= 1'b0;
    end else begin
      out_valid <= vld_d;
      dma_hit   <= hit_d;
      fallback  <= fb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_word_addr <= '0;
      byte_lane     <= '0;
    end else if (addr_en) begin
      cpu_word_addr <= word_d;
      byte_lane     <= lane_d;
    end
  end
endmodule

// File: rtl/fwdma_xlate_top.sv
module fwdma_xlate_top
  import fwdma_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int IDSEL_W = 4,
  parameter int LANE_W  = 3,
  parameter int ALIGN_W = 4,
  localparam int CPU_AW = 2 * REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic               cyc_valid,
  input  logic               cyc_write,
  input  logic [REG_W-1:0]   cyc_addr,
  input  logic [IDSEL_W-1:0] cyc_idsel,
  output logic               out_valid,
  output logic               dma_hit,
  output logic               fallback,
  output logic [CPU_AW-1:0]  cpu_word_addr,
  output logic [LANE_W-1:0]  byte_lane
);
  logic [REG_W-1:0]  ctrl_q, mask_q, start_q, end_q, base_lo_q, base_hi_q;
  logic              map_hit;
  logic [CPU_AW-1:0] map_addr;

  fwdma_cfg_regs #(.REG_W(REG_W), .ALIGN_W(ALIGN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .ctrl(ctrl_q), .mask(mask_q), .start_off(start_q),
    .end_off(end_q), .base_lo(base_lo_q), .base_hi(base_hi_q)
  );

  fwdma_map #(.REG_W(REG_W), .IDSEL_W(IDSEL_W)) u_map (
    .valid(cyc_valid), .is_write(cyc_write), .addr(cyc_addr), .idsel(cyc_idsel),
    .rd_en(ctrl_q[CTRL_RD_EN]), .wr_en(ctrl_q[CTRL_WR_EN]),
    .flt_en(ctrl_q[CTRL_FLT_EN]),
    .flt_val(ctrl_q[CTRL_FLT_LO +: IDSEL_W]),
    .mask(mask_q), .start_off(start_q), .end_off(end_q),
    .base({base_hi_q, base_lo_q}), .hit(map_hit), .cpu_addr(map_addr)
  );

  fwdma_result_reg #(.CPU_AW(CPU_AW), .LANE_W(LANE_W)) u_res (
    .clk(clk), .rst_n(rst_n), .valid(cyc_valid), .hit(map_hit),
    .cpu_addr(map_addr), .out_valid(out_valid), .dma_hit(dma_hit),
    .fallback(fallback), .cpu_word_addr(cpu_word_addr), .byte_lane(byte_lane)
  );
endmodule

// File: rtl/fwdma_xlate_chk.sv
module fwdma_xlate_chk #(
  parameter int REG_W   = 32,
  parameter int IDSEL_W = 4,
  parameter int LANE_W  = 3,
  parameter int ALIGN_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cyc_valid,
  input logic [IDSEL_W-1:0] cyc_idsel,
  input logic               flt_en,
  input logic [IDSEL_W-1:0] flt_val,
  input logic [2:0]         cfg_sel,
  input logic [ALIGN_W-1:0] rdata_low,
  input logic               out_valid,
  input logic               dma_hit,
  input logic               fallback,
  input logic [LANE_W-1:0]  word_low
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (dma_hit ^ fallback));

  assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!dma_hit && !fallback));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(cyc_valid)));

  assert_word_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (word_low == '0));

  assert_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && dma_hit && $past(flt_en)) |-> ($past(cyc_idsel) == $past(flt_val)));

  assert_hardwired_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_sel == 3'd4) || (cfg_sel == 3'd6)) |-> (rdata_low == '0));
endmodule

bind fwdma_xlate_top fwdma_xlate_chk #(
  .REG_W(REG_W), .IDSEL_W(IDSEL_W), .LANE_W(LANE_W), .ALIGN_W(ALIGN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_idsel(cyc_idsel),
  .flt_en(ctrl_q[2]), .flt_val(ctrl_q[4 +: IDSEL_W]), .cfg_sel(cfg_sel),
  .rdata_low(cfg_rdata[ALIGN_W-1:0]), .out_valid(out_valid),
  .dma_hit(dma_hit), .fallback(fallback), .word_low(cpu_word_addr[LANE_W-1:0])
);

// File: tb/test_fwdma_xlate_top.sv
module test_fwdma_xlate_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cyc_valid = 1'b0;
  logic        cyc_write = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic [3:0]  cyc_idsel = '0;
  logic        out_valid, dma_hit, fallback;
  logic [63:0] cpu_word_addr;
  logic [2:0]  byte_lane;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwdma_xlate_top i_fwdma_xlate_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cyc_valid(cyc_valid),
    .cyc_write(cyc_write), .cyc_addr(cyc_addr), .cyc_idsel(cyc_idsel),
    .out_valid(out_valid), .dma_hit(dma_hit), .fallback(fallback),
    .cpu_word_addr(cpu_word_addr), .byte_lane(byte_lane)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  ids;
    logic        hit;
    logic [63:0] word;
    logic [2:0]  lane;
  } vec_t;

  // mask 0xFFFF, start 0x1000, end 0x8FFF, base 0x1_2000_0000, both directions
  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h0000_0000, 4'h0, 1'b1, 64'h1_2000_1000, 3'd0},
    '{1'b0, 32'h00FF_0005, 4'h1, 1'b1, 64'h1_2000_1000, 3'd5},
    '{1'b1, 32'h0000_7FFF, 4'h2, 1'b1, 64'h1_2000_8FF8, 3'd7},
    '{1'b0, 32'h0000_8000, 4'h3, 1'b0, 64'h0,           3'd0},
    '{1'b1, 32'hABCD_1234, 4'h4, 1'b1, 64'h1_2000_2230, 3'd4},
    '{1'b0, 32'h0000_FFFF, 4'h5, 1'b0, 64'h0,           3'd0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input string req, input logic [2:0] sel, input logic [31:0] exp);
    cfg_sel = sel;
    #1;
    check(req, {32'h0, cfg_rdata}, {32'h0, exp});
  endtask

  // drive one cycle, check at the falling edge after the capturing edge
  task automatic run(input string req, input logic wr, input logic [31:0] addr,
                     input logic [3:0] ids, input logic exp_hit,
                     input logic [63:0] exp_word, input logic [2:0] exp_lane);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_write = wr; cyc_addr = addr; cyc_idsel = ids;
    @(negedge clk);
    cyc_valid = 1'b0;
    check({req, " valid"}, {63'h0, out_valid}, 64'h1);
    check({req, " hit"}, {63'h0, dma_hit}, {63'h0, exp_hit});
    check({req, " fallback"}, {63'h0, fallback}, {63'h0, !exp_hit});
    if (exp_hit) begin
      check({req, " word"}, cpu_word_addr, exp_word);
      check({req, " lane"}, {61'h0, byte_lane}, {61'h0, exp_lane});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 7; s++) cfg_read("R1 reg reset", 3'(s), 32'h0);
    check("R1 out_valid", {63'h0, out_valid}, 64'h0);
    check("R1 dma_hit", {63'h0, dma_hit}, 64'h0);
    check("R1 fallback", {63'h0, fallback}, 64'h0);

    // R2: writes, readback, hardwired low bits
    cfg_write(3'd4, 32'hFFFF_FFFF); cfg_read("R2 base_lo", 3'd4, 32'hFFFF_FFF0);
    cfg_write(3'd6, 32'h1234_5677); cfg_read("R2 length", 3'd6, 32'h1234_5670);
    cfg_write(3'd1, 32'h0000_FFFF); cfg_read("R2 mask", 3'd1, 32'h0000_FFFF);

    // table configuration
    cfg_write(3'd2, 32'h0000_1000);
    cfg_write(3'd3, 32'h0000_8FFF);
    cfg_write(3'd4, 32'h2000_0000);
    cfg_write(3'd5, 32'h0000_0001);
    cfg_write(3'd0, 32'h0000_0003);
    cfg_read("R2 ctrl", 3'd0, 32'h0000_0003);

    // R3 R4 R5: masked, windowed, relocated
    for (int i = 0; i < NVEC; i++)
      run("R3/R4/R5 table", VECS[i].wr, VECS[i].addr, VECS[i].ids,
          VECS[i].hit, VECS[i].word, VECS[i].lane);

    // R9: result lasts one cycle, then idle; R8: idle gives neither flag
    @(negedge clk);
    check("R9 one cycle", {63'h0, out_valid}, 64'h0);
    check("R8 idle hit", {63'h0, dma_hit}, 64'h0);
    check("R8 idle fallback", {63'h0, fallback}, 64'h0);

    // R6: direction enables
    cfg_write(3'd0, 32'h0000_0001);
    run("R6 read enabled", 1'b0, 32'h0000_0010, 4'h0, 1'b1, 64'h1_2000_1010, 3'd0);
    run("R6 write disabled", 1'b1, 32'h0000_0010, 4'h0, 1'b0, 64'h0, 3'd0);
    cfg_write(3'd0, 32'h0000_0002);
    run("R6 read disabled", 1'b0, 32'h0000_0010, 4'h0, 1'b0, 64'h0, 3'd0);
    run("R6 write enabled", 1'b1, 32'h0000_0013, 4'h0, 1'b1, 64'h1_2000_1010, 3'd3);

    // R7: ID select filter (value 5 in bits 7:4, enable bit 2)
    cfg_write(3'd0, 32'h0000_0057);
    run("R7 match", 1'b0, 32'h0000_0020, 4'h5, 1'b1, 64'h1_2000_1020, 3'd0);
    run("R7 mismatch", 1'b0, 32'h0000_0020, 4'h3, 1'b0, 64'h0, 3'd0);
    cfg_write(3'd0, 32'h0000_0053);
    run("R7 filter off", 1'b0, 32'h0000_0020, 4'h3, 1'b1, 64'h1_2000_1020, 3'd0);

    // R4: offset sum must not wrap into the window
    cfg_write(3'd1, 32'hFFFF_FFFF);
    cfg_write(3'd2, 32'hFFFF_FFF0);
    cfg_write(3'd3, 32'hFFFF_FFFF);
    run("R4 top edge", 1'b0, 32'h0000_000F, 4'h0, 1'b1, 64'h2_1FFF_FFF8, 3'd7);
    run("R4 no wrap", 1'b0, 32'h0000_0020, 4'h0, 1'b0, 64'h0, 3'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule